// File: doc/BRIEF.md
# DMX512 Receiver with End-of-Frame Detection

This block takes one already-synchronised DMX512 receive line and turns it into a stream of bytes. It waits for a BREAK, a low period of at least 22 bit times. It then requires a Mark After Break of at least 2 bit times. After that it deframes slots. Each slot is a low start bit, eight data bits sent LSB first, and two high stop bits. The first slot of a frame is the START code. The block publishes it on `start_code` and does not emit it as data. Every later slot is emitted for one clock on `slot_valid`, together with its 1-based `slot_index`.

The frame does not wait for the next BREAK to end. It closes when no start bit appears within 25 bit times after the end of the last stop bit. It also closes as soon as a slot fails its start-bit or stop-bit check, which covers a new BREAK arriving with no Mark Before Break. On closing it pulses `frame_done` with the number of data slots in `frame_len`, so a short frame is reported at its exact length and with low latency. Once a frame ends, the receiver ignores the line until a full BREAK and MAB have been seen again. A long idle-high line is not an error.

All timing is counted in clocks, derived from `CLKS_PER_BIT` (4 us per bit). The controller has these states:
- `ST_HUNT`: waiting for a low level.
- `ST_BREAK`: measuring the low run. On the rising edge it goes to `ST_MAB` if the run was long enough, otherwise back to `ST_HUNT`.
- `ST_MAB`: measuring the high run. On the falling edge it goes to `ST_START` if the mark was long enough, otherwise to `ST_HUNT`.
- `ST_START`: checks the start bit at half a bit time. If the line is low it goes to `ST_DATA`. If the line is high it counts a framing error and returns to `ST_HUNT`.
- `ST_DATA`: takes eight centre samples, then goes to `ST_STOP`.
- `ST_STOP`: checks two stop bits. A low stop bit is a framing error and returns to `ST_HUNT`. Two high stop bits complete the slot and lead to `ST_GAP`.
- `ST_GAP`: a falling edge leads to `ST_START`. The inter-slot timeout leads to `ST_HUNT` with `frame_done`.

Top module: `dmx_rx`

## Requirements
- R1: After reset, `slot_valid`, `frame_done` and `framing_error` are low, and `slot_index`, `frame_len` and `start_code` are zero.
- R2: A frame is entered only after the line has been low for at least 22 bit times and then high for at least 2 bit times. Slots that follow a shorter low period produce no output.
- R3: A mark after the BREAK that is shorter than 2 bit times is rejected, and the slots that follow produce no output.
- R4: A slot is a low start bit, eight data bits LSB first, and two high stop bits, each sampled at its bit centre. A start bit that is no longer low half a bit time after its falling edge counts as a framing error.
- R5: The first slot of a frame is placed on `start_code`, whether zero or not, and is not emitted. Data slot k (k = 1, 2, ...) pulses `slot_valid` for one clock with its byte on `slot_data` and k on `slot_index`.
- R6: If no start bit begins within 25 bit times after the end of the last stop bit, `frame_done` pulses once with `frame_len` equal to the number of data slots. The pulse comes no later than a few clocks after the timeout expires.
- R7: A low stop bit pulses `framing_error` and does not emit that slot. If a START code was already received, `frame_done` pulses with the count of data slots emitted so far.
- R8: Data slots beyond `MAX_SLOTS` are not emitted, and `frame_len` stays at `MAX_SLOTS`.
- R9: After a frame ends, slots that arrive with no new BREAK and MAB produce no output.
- R10: An idle-high line of any length outside a frame pulses neither `framing_error` nor `frame_done`.
- R11: A BREAK that starts right after the last stop bit ends the current frame with its correct `frame_len`, and the frame that follows is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Synchronised receive line, idle high |
| slot_valid | output | 1 | One-clock pulse for each emitted data slot |
| slot_data | output | 8 | Byte of the emitted data slot |
| slot_index | output | IDX_W | 1-based index of the emitted data slot |
| frame_done | output | 1 | One-clock pulse when a frame closes |
| frame_len | output | IDX_W | Number of data slots in the closed frame |
| start_code | output | 8 | START code of the current or last frame |
| framing_error | output | 1 | One-clock pulse on a bad start bit or stop bit |

## Verification
The bench sweeps the frame length from zero to two past the slot limit, with zero and non-zero START codes. A receiver that miscounts or sets no cap would report a wrong `frame_len`, or would emit slots past the limit. The bench also drives BREAKs and marks just under their minimums, a bad stop bit on the START slot and on a data slot, and a start-bit glitch shorter than half a bit. A design with loose thresholds would open frames it should reject, and one that is sloppy about errors would emit a corrupt byte or lose the count. The remaining cases are slots sent after a timeout with no BREAK, and a BREAK that follows the last stop bit with no gap. Here a design that stays open would emit stray data, or would merge two frames into one.

// File: rtl/dmx_rx_pkg.sv
`timescale 1ns/1ps
package dmx_rx_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_BREAK,
        ST_MAB,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_GAP
    } rx_state_t;
endpackage

// File: rtl/dmx_rx_runlen.sv
`timescale 1ns/1ps
// Saturating length of the current run of one line level.
module dmx_rx_runlen #(
    parameter int LIMIT = 16,
    parameter int W = 5,
    parameter bit LEVEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line,
    output logic [W-1:0] run
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (line != LEVEL) begin
            run <= '0;
        end else if (run != W'(LIMIT)) begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/dmx_rx_deser.sv
`timescale 1ns/1ps
// LSB-first shift register for the eight data bits of a slot.
module dmx_rx_deser #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (shift_en) begin
            value <= {bit_in, value[BITS-1:1]};
        end
    end
endmodule

// File: rtl/dmx_rx.sv
`timescale 1ns/1ps
module dmx_rx
    import dmx_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 800,
    parameter int MAX_SLOTS    = 512,
    localparam int IDX_W       = $clog2(MAX_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx,
    output logic             slot_valid,
    output logic [7:0]       slot_data,
    output logic [IDX_W-1:0] slot_index,
    output logic             frame_done,
    output logic [IDX_W-1:0] frame_len,
    output logic [7:0]       start_code,
    output logic             framing_error
);
    localparam int HALF_CLKS    = CLKS_PER_BIT / 2;
    localparam int BREAK_CLKS   = 22 * CLKS_PER_BIT;
    localparam int MAB_CLKS     = 2 * CLKS_PER_BIT;
    localparam int TIMEOUT_CLKS = 25 * CLKS_PER_BIT;
    localparam int GAP_LIMIT    = TIMEOUT_CLKS + HALF_CLKS;
    localparam int TMR_W        = $clog2(GAP_LIMIT + 1);
    localparam int LOW_W        = $clog2(BREAK_CLKS + 1);
    localparam int HIGH_W       = $clog2(MAB_CLKS + 1);

    rx_state_t         state, nxt;
    logic [TMR_W-1:0]  tmr;
    logic [2:0]        bitn;
    logic [LOW_W-1:0]  low_run;
    logic [HIGH_W-1:0] high_run;
    logic [7:0]        shift_byte;
    logic              frame_open;
    logic [IDX_W-1:0]  slot_cnt;

    logic brk_ok, mab_ok, tick, half_hit, gap_hit;
    logic ev_slot, ev_err, ev_timeout, shift_en;

    dmx_rx_runlen #(.LIMIT(BREAK_CLKS), .W(LOW_W), .LEVEL(1'b0)) u_low_run (
        .clk (clk), .rst (rst), .line (rx), .run (low_run)
    );

    dmx_rx_runlen #(.LIMIT(MAB_CLKS), .W(HIGH_W), .LEVEL(1'b1)) u_high_run (
        .clk (clk), .rst (rst), .line (rx), .run (high_run)
    );

    dmx_rx_deser #(.BITS(8)) u_deser (
        .clk (clk), .rst (rst), .shift_en (shift_en), .bit_in (rx), .value (shift_byte)
    );

    assign brk_ok   = (low_run == LOW_W'(BREAK_CLKS));
    assign mab_ok   = (high_run == HIGH_W'(MAB_CLKS));
    assign tick     = (tmr == TMR_W'(CLKS_PER_BIT - 1));
    assign half_hit = (tmr == TMR_W'(HALF_CLKS - 1));
    assign gap_hit  = (tmr == TMR_W'(GAP_LIMIT - 1));

    assign shift_en   = (state == ST_DATA) && tick;
    assign ev_slot    = (state == ST_STOP) && tick && rx && bitn[0];
    assign ev_err     = ((state == ST_START) && half_hit && rx) ||
                        ((state == ST_STOP) && tick && !rx);
    assign ev_timeout = (state == ST_GAP) && rx && gap_hit;

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:  if (!rx) nxt = ST_BREAK;
            ST_BREAK: if (rx) nxt = brk_ok ? ST_MAB : ST_HUNT;
            ST_MAB:   if (!rx) nxt = mab_ok ? ST_START : ST_HUNT;
            ST_START: if (half_hit) nxt = rx ? ST_HUNT : ST_DATA;
            ST_DATA:  if (tick && bitn == 3'd7) nxt = ST_STOP;
            ST_STOP: begin
                if (tick) begin
                    if (!rx) nxt = ST_HUNT;
                    else if (bitn[0]) nxt = ST_GAP;
                end
            end
            ST_GAP: begin
                if (!rx) nxt = ST_START;
                else if (gap_hit) nxt = ST_HUNT;
            end
            default: nxt = ST_HUNT;
        endcase
    end

    // State register with its bit timer and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HUNT;
            tmr   <= '0;
            bitn  <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                tmr  <= '0;
                bitn <= '0;
            end else begin
                unique case (state)
                    ST_DATA, ST_STOP: begin
                        tmr <= tick ? '0 : tmr + 1'b1;
                        if (tick) bitn <= bitn + 1'b1;
                    end
                    ST_START, ST_GAP: tmr <= tmr + 1'b1;
                    default: tmr <= '0;
                endcase
            end
        end
    end

    // Outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid    <= 1'b0;
            slot_data     <= '0;
            slot_index    <= '0;
            frame_done    <= 1'b0;
            frame_len     <= '0;
            start_code    <= '0;
            framing_error <= 1'b0;
            frame_open    <= 1'b0;
            slot_cnt      <= '0;
        end else begin
            slot_valid    <= 1'b0;
            frame_done    <= 1'b0;
            framing_error <= ev_err;
            if (ev_slot) begin
                if (!frame_open) begin
                    start_code <= shift_byte;
                    frame_open <= 1'b1;
                    slot_cnt   <= '0;
                end else if (slot_cnt != IDX_W'(MAX_SLOTS)) begin
                    slot_cnt   <= slot_cnt + 1'b1;
                    slot_valid <= 1'b1;
                    slot_data  <= shift_byte;
                    slot_index <= slot_cnt + 1'b1;
                end
            end
            if ((ev_err || ev_timeout) && frame_open) begin
                frame_done <= 1'b1;
                frame_len  <= slot_cnt;
                frame_open <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmx_rx_checker.sv
`timescale 1ns/1ps
module dmx_rx_checker #(
    parameter int IDX_W     = 10,
    parameter int MAX_SLOTS = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             slot_valid,
    input logic [IDX_W-1:0] slot_index,
    input logic             frame_done,
    input logic [IDX_W-1:0] frame_len,
    input logic             framing_error
);
    logic [IDX_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else if (frame_done) seen <= '0;
        else if (slot_valid) seen <= seen + 1'b1;
    end

    p_index_step_r5: assert property (@(posedge clk) disable iff (rst)
        slot_valid |-> slot_index == IDX_W'(seen + 1'b1));

    p_len_matches_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> frame_len == seen);

    p_index_cap_r8: assert property (@(posedge clk) disable iff (rst)
        slot_valid |-> (slot_index != '0) && (slot_index <= IDX_W'(MAX_SLOTS)));

    p_slot_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        slot_valid |=> !slot_valid);

    p_err_no_slot_r7: assert property (@(posedge clk) disable iff (rst)
        framing_error |-> !slot_valid);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

bind dmx_rx dmx_rx_checker #(.IDX_W(IDX_W), .MAX_SLOTS(MAX_SLOTS)) u_dmx_rx_checker (
    .clk           (clk),
    .rst           (rst),
    .slot_valid    (slot_valid),
    .slot_index    (slot_index),
    .frame_done    (frame_done),
    .frame_len     (frame_len),
    .framing_error (framing_error)
);

// File: tb/dmx_rx_bench.sv
`timescale 1ns/1ps
module dmx_rx_bench;
    localparam int CPB   = 8;
    localparam int MAXS  = 12;
    localparam int IDX_W = $clog2(MAXS + 1);
    localparam int TO    = 25 * CPB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx  = 1'b1;
    logic             slot_valid, frame_done, framing_error;
    logic [7:0]       slot_data, start_code;
    logic [IDX_W-1:0] slot_index, frame_len;

    always #2.5 clk = ~clk;

    dmx_rx #(.CLKS_PER_BIT(CPB), .MAX_SLOTS(MAXS)) u_dmx_rx (
        .clk (clk), .rst (rst), .rx (rx),
        .slot_valid (slot_valid), .slot_data (slot_data), .slot_index (slot_index),
        .frame_done (frame_done), .frame_len (frame_len),
        .start_code (start_code), .framing_error (framing_error)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    int nrx, ndone, nerr, t_done, t_end;
    int got_data [16];
    int got_idx  [16];
    int done_len [4];
    int last_sc;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (slot_valid) begin
                if (nrx < 16) begin
                    got_data[nrx] = int'(slot_data);
                    got_idx[nrx]  = int'(slot_index);
                end
                nrx++;
            end
            if (frame_done) begin
                if (ndone < 4) done_len[ndone] = int'(frame_len);
                last_sc = int'(start_code);
                t_done  = cyc;
                ndone++;
            end
            if (framing_error) nerr++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nrx = 0; ndone = 0; nerr = 0; t_done = 0;
    endtask

    task automatic drive(input bit v, input int cycles);
        rx = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send_slot(input int b, input bit good_stop);
        drive(1'b0, CPB);
        for (int k = 0; k < 8; k++) drive(b[k], CPB);
        drive(good_stop, CPB);
        drive(1'b1, CPB);
        t_end = cyc;
    endtask

    function automatic int byte_of(input int seed, input int i);
        return (seed * 29 + i * 53 + 7) & 255;
    endfunction

    task automatic send_frame(input int brk_bits, input int mab_cycles,
                              input int sc, input int n, input int seed);
        drive(1'b0, brk_bits * CPB);
        drive(1'b1, mab_cycles);
        send_slot(sc, 1'b1);
        for (int i = 0; i < n; i++) send_slot(byte_of(seed, i), 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!slot_valid && !frame_done && !framing_error, "R1", "pulses in reset",
              int'(slot_valid) + int'(frame_done) + int'(framing_error), 0);
        check(slot_index == 0 && frame_len == 0 && start_code == 0, "R1", "fields in reset",
              int'(slot_index) + int'(frame_len) + int'(start_code), 0);
        rst = 1'b0;
        drive(1'b1, 20 * CPB);

        // R5, R6, R8: sweep of frame lengths
        for (int n = 0; n <= MAXS + 2; n++) begin
            int sc, exp_n;
            sc    = (n % 3 == 0) ? 0 : ((8'h5A ^ (n * 17)) & 255);
            exp_n = (n < MAXS) ? n : MAXS;
            clear_mon();
            send_frame(23, 2 * CPB, sc, n, n);
            drive(1'b1, 30 * CPB);
            check(ndone == 1, "R6", "frame_done count", ndone, 1);
            check(done_len[0] == exp_n, "R8", "frame_len", done_len[0], exp_n);
            check(last_sc == sc, "R5", "start_code", last_sc, sc);
            check(nrx == exp_n, "R5", "emitted slot count", nrx, exp_n);
            for (int i = 0; i < exp_n; i++) begin
                check(got_data[i] == byte_of(n, i), "R4", "slot_data", got_data[i], byte_of(n, i));
                check(got_idx[i] == i + 1, "R5", "slot_index", got_idx[i], i + 1);
            end
            check(t_done - t_end >= TO - 1 && t_done - t_end <= TO + 4, "R6",
                  "timeout latency", t_done - t_end, TO + 1);
            check(nerr == 0, "R10", "no error on clean frame", nerr, 0);
        end

        // R2: BREAK too short
        clear_mon();
        send_frame(20, 2 * CPB, 0, 3, 5);
        drive(1'b1, 30 * CPB);
        check(nrx == 0 && ndone == 0, "R2", "short break output", nrx + ndone, 0);

        // R3: MAB too short
        clear_mon();
        send_frame(23, CPB, 0, 3, 6);
        drive(1'b1, 30 * CPB);
        check(nrx == 0 && ndone == 0, "R3", "short MAB output", nrx + ndone, 0);

        // R7: bad stop bit on a data slot
        clear_mon();
        send_frame(23, 2 * CPB, 0, 3, 7);
        send_slot(8'h3C, 1'b0);
        drive(1'b1, 30 * CPB);
        check(nerr == 1, "R7", "framing_error count", nerr, 1);
        check(ndone == 1 && done_len[0] == 3, "R7", "frame_len after error", done_len[0], 3);
        check(nrx == 3, "R7", "bad slot not emitted", nrx, 3);

        // R7: bad stop bit on the START slot
        clear_mon();
        drive(1'b0, 23 * CPB);
        drive(1'b1, 2 * CPB);
        send_slot(8'h00, 1'b0);
        drive(1'b1, 30 * CPB);
        check(nerr == 1 && ndone == 0, "R7", "error before START no done", ndone, 0);

        // R4: start-bit glitch shorter than half a bit
        clear_mon();
        send_frame(23, 2 * CPB, 0, 2, 8);
        drive(1'b0, 2);
        drive(1'b1, 30 * CPB);
        check(nerr == 1, "R4", "glitch counted as error", nerr, 1);
        check(ndone == 1 && done_len[0] == 2, "R4", "frame closed by glitch", done_len[0], 2);

        // R9: slots after timeout with no BREAK
        clear_mon();
        send_frame(23, 2 * CPB, 0, 2, 9);
        drive(1'b1, 30 * CPB);
        clear_mon();
        for (int i = 0; i < 3; i++) send_slot(8'hA5 ^ i, 1'b1);
        drive(1'b1, 30 * CPB);
        check(nrx == 0 && ndone == 0, "R9", "output without BREAK", nrx + ndone, 0);

        // R10: long idle
        clear_mon();
        drive(1'b1, 400 * CPB);
        check(nerr == 0 && ndone == 0, "R10", "idle output", nerr + ndone, 0);

        // R11: BREAK right after last stop bit
        clear_mon();
        send_frame(23, 2 * CPB, 8'h17, 4, 10);
        send_frame(23, 2 * CPB, 0, 2, 11);
        drive(1'b1, 30 * CPB);
        check(ndone == 2, "R11", "two frames closed", ndone, 2);
        check(done_len[0] == 4, "R11", "first frame_len", done_len[0], 4);
        check(done_len[1] == 2, "R11", "second frame_len", done_len[1], 2);
        check(nrx == 6, "R11", "total slots", nrx, 6);
        check(nrx == 6 && got_data[4] == byte_of(11, 0) && got_idx[4] == 1, "R11",
              "second frame first slot", got_data[4], byte_of(11, 0));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule